// File: doc/BRIEF.md
# UART Receiver with Standby Wakeup

This block is the receive half of an asynchronous serial port. A baud-rate enable (`tick`) arrives 16 times per bit period, and the block samples the serial line `rxd` on each tick. It finds the start bit and takes three samples near the middle of every bit. From these it recovers a character of 8 or 9 data bits, sent least significant bit first. It then checks the stop bit and presents the character on a register-style status port, where it sets a receive-full flag, a framing-error flag and an idle-line flag.

In a system with several receivers on one line, software can put this receiver into standby with a one-cycle `standby_set` pulse. While the receiver is in standby, the interrupt output is held low. Characters that are not wake events are discarded, and the data register and the flags are left unchanged. The hardware leaves standby on its own, using one of two wake methods. In address-mark mode, a character whose top data bit is 1 ends standby and is delivered like a normal character; software then compares it with its own address. In idle-line mode, a full character time of continuous 1s ends standby, and this wake sets no flag.

Top module: `uart_standby_rx`

## Requirements
- R1: While `rst_n` is low, `rx_data` is 0 and `rx_full`, `frame_err`, `idle_flag`, `standby` and `irq` are all 0.
- R2: With `nine_bit`=0, a frame made of one low start bit, 8 data bits (LSB first) and a high stop bit, each 16 ticks long, ends with `rx_data[7:0]` equal to the data, `rx_data[8]`=0, `rx_full`=1 and `frame_err`=0. The stop decision is made at tick 154 counted from the start edge.
- R3: With `nine_bit`=1, a frame of 9 data bits is received into `rx_data[8:0]`. The stop decision is made at tick 170.
- R4: A start edge is a low sample on a tick after a high sample. If the majority of the start-bit samples at ticks 8, 9 and 10 is high, the receiver abandons the frame and delivers no character.
- R5: Outside standby, a low majority for the stop bit still delivers the character and sets `frame_err`=1.
- R6: A one-cycle `rd_data` pulse clears `rx_full` and `frame_err`.
- R7: After a character has started, a run of 1s one frame long (160 ticks for 8-bit frames, 176 for 9-bit frames) sets `idle_flag` once when the receiver is not in standby. `idle_ack` clears the flag, and the flag is not set again until another start edge occurs.
- R8: When `idle_after_stop`=0, 1s are counted from the end of the start bit. When it is 1, counting begins only after the stop decision.
- R9: While `standby`=1, `irq` is 0. A character that is not a wake event leaves `rx_data`, `rx_full`, `frame_err` and `idle_flag` unchanged.
- R10: When `wake_on_addr`=1 and the receiver is in standby, a character whose top data bit is 1 (bit 7 for 8-bit frames, bit 8 for 9-bit frames) clears `standby`, loads `rx_data` and sets `rx_full`.
- R11: When `wake_on_addr`=0 and the receiver is in standby, an idle character clears `standby` without setting `idle_flag` or `rx_full`. A `standby_set` pulse restarts the idle count, so a line that is already idle wakes the receiver one frame time later.
- R12: `irq` is the OR of `rx_full & ie_full`, `idle_flag & ie_idle` and `frame_err & ie_err`, and it is forced to 0 while in standby.
- R13: Each bit value is the majority of three samples, so one inverted sample at tick 8, 9 or 10 of a bit does not change the received data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Sample enable, 16 per bit period |
| rxd | input | 1 | Serial line, idle high |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wake_on_addr | input | 1 | 1 selects address-mark wake, 0 selects idle-line wake |
| idle_after_stop | input | 1 | 1 starts the idle count after the stop bit, 0 after the start bit |
| standby_set | input | 1 | One-cycle pulse that enters standby |
| rd_data | input | 1 | Data register read strobe; clears rx_full and frame_err |
| idle_ack | input | 1 | Clears idle_flag |
| ie_full | input | 1 | Interrupt enable for rx_full |
| ie_idle | input | 1 | Interrupt enable for idle_flag |
| ie_err | input | 1 | Interrupt enable for frame_err |
| rx_data | output | 9 | Last accepted character |
| rx_full | output | 1 | Receive-full flag |
| idle_flag | output | 1 | Idle-line flag |
| frame_err | output | 1 | Stop bit was sampled low |
| standby | output | 1 | Receiver is in standby |
| irq | output | 1 | Interrupt request |

## Verification
A frame counter that is off by a single tick moves the sampling point. The fault then shows as shifted or corrupted `rx_data` bits, or as a wrong `frame_err`, on the first character after it occurs, and every sweep value exposes it. A fault in the idle counter shows as `idle_flag` or a line wake arriving in the wrong window. The bench samples each side of the expected tick, far enough apart to separate the two counting modes within one frame time. A wrong standby or accept decision shows on the next character as data that leaks through, a flag that rises during standby, or a wake that never comes.

// File: rtl/uart_sbrx_pkg.sv
`timescale 1ns/1ps
package uart_sbrx_pkg;
  localparam int DB_SHORT = 8;
  localparam int DB_LONG  = 9;

  typedef enum logic {FR_HUNT, FR_RECV} fr_state_t;

  function automatic int data_bits(input logic nine);
    return nine ? DB_LONG : DB_SHORT;
  endfunction

  // tick (from the start edge) of the final stop-bit sample
  function automatic int stop_tick(input logic nine, input int ovs);
    return (data_bits(nine) + 1) * ovs + ovs / 2 + 2;
  endfunction

  // number of consecutive high ticks forming an idle character
  function automatic int idle_ticks(input logic nine, input int ovs);
    return (data_bits(nine) + 2) * ovs;
  endfunction

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/sbrx_frame.sv
`timescale 1ns/1ps
module sbrx_frame
  import uart_sbrx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               rxd,
  input  logic               nine,
  output logic               busy,
  output logic               start_evt,
  output logic               done,
  output logic [DB_LONG-1:0] data,
  output logic               stop_ok,
  output logic               addr_bit
);
  localparam int PH_W = $clog2(OVS);
  localparam int PH_A = OVS / 2;
  localparam int PH_B = OVS / 2 + 1;
  localparam int PH_C = OVS / 2 + 2;

  fr_state_t          st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               last_hi_q, s_a_q, s_b_q, nine_q;
  logic [DB_LONG-1:0] sh_q;
  logic               done_q, stop_ok_q, addr_q;
  logic [DB_LONG-1:0] data_q;

  logic [PH_W-1:0]       phase;
  logic [CNT_W-PH_W-1:0] bitn;
  logic                  vote;

  assign phase     = cnt_q[PH_W-1:0];
  assign bitn      = cnt_q[CNT_W-1:PH_W];
  assign vote      = vote3(s_a_q, s_b_q, rxd);
  assign start_evt = tick && (st_q == FR_HUNT) && !rxd && last_hi_q;
  assign busy      = (st_q == FR_RECV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= FR_HUNT;
      cnt_q     <= '0;
      last_hi_q <= 1'b0;
      s_a_q     <= 1'b1;
      s_b_q     <= 1'b1;
      nine_q    <= 1'b0;
      sh_q      <= '0;
      done_q    <= 1'b0;
      stop_ok_q <= 1'b1;
      addr_q    <= 1'b0;
      data_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (tick) begin
        last_hi_q <= rxd;
        case (st_q)
          FR_HUNT: begin
            if (start_evt) begin
              st_q   <= FR_RECV;
              cnt_q  <= CNT_W'(1);
              nine_q <= nine;
              sh_q   <= '0;
            end
          end
          default: begin
            cnt_q <= cnt_q + 1'b1;
            if (phase == PH_W'(PH_A)) s_a_q <= rxd;
            if (phase == PH_W'(PH_B)) s_b_q <= rxd;
            if (phase == PH_W'(PH_C)) begin
              if (bitn == '0) begin
                if (vote) st_q <= FR_HUNT;   // false start
              end else if (int'(bitn) <= data_bits(nine_q)) begin
                sh_q[int'(bitn) - 1] <= vote;
              end else begin
                done_q    <= 1'b1;
                stop_ok_q <= vote;
                data_q    <= nine_q ? sh_q : {1'b0, sh_q[DB_SHORT-1:0]};
                addr_q    <= nine_q ? sh_q[DB_LONG-1] : sh_q[DB_SHORT-1];
                st_q      <= FR_HUNT;
              end
            end
          end
        endcase
      end
    end
  end

  assign done     = done_q;
  assign data     = data_q;
  assign stop_ok  = stop_ok_q;
  assign addr_bit = addr_q;

  // R2 / R3: a character completes exactly at the stop-decision tick
  a_r2_done_at_stop_tick: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(cnt_q) == CNT_W'(stop_tick($past(nine_q), OVS))));

  // R4: a high start vote returns to hunting with no character
  a_r4_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && busy && bitn == '0 && phase == PH_W'(PH_C) && vote)
      |=> (!busy && !done_q));
endmodule

// File: rtl/sbrx_idle.sv
`timescale 1ns/1ps
module sbrx_idle
  import uart_sbrx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxd,
  input  logic nine,
  input  logic after_stop,
  input  logic busy,
  input  logic start_evt,
  input  logic restart,
  output logic idle_evt
);
  logic [CNT_W-1:0] ones_q;
  logic             armed_q;
  logic             hold;
  logic             at_end;

  assign hold     = !rxd || (after_stop && busy);
  assign at_end   = (ones_q == CNT_W'(idle_ticks(nine, OVS) - 1));
  assign idle_evt = tick && armed_q && !hold && at_end && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q  <= '0;
      armed_q <= 1'b0;
    end else if (restart) begin
      ones_q  <= '0;
      armed_q <= 1'b1;
    end else if (tick) begin
      if (start_evt) armed_q <= 1'b1;
      if (hold) begin
        ones_q <= '0;
      end else if (armed_q) begin
        if (at_end) begin
          ones_q  <= '0;
          armed_q <= 1'b0;
        end else begin
          ones_q <= ones_q + 1'b1;
        end
      end
    end
  end

  // R7: one idle event per idle period
  a_r7_idle_single: assert property (@(posedge clk) disable iff (!rst_n)
    idle_evt |=> !idle_evt);

  // R8: counting deferred until the stop decision when selected
  a_r8_no_count_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (after_stop && busy && tick && !restart) |=> (ones_q == '0));
endmodule

// File: rtl/sbrx_wake.sv
`timescale 1ns/1ps
module sbrx_wake
  import uart_sbrx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_done,
  input  logic [DB_LONG-1:0] frame_data,
  input  logic               stop_ok,
  input  logic               addr_bit,
  input  logic               idle_evt,
  input  logic               wake_on_addr,
  input  logic               standby_set,
  input  logic               rd_data,
  input  logic               idle_ack,
  input  logic               ie_full,
  input  logic               ie_idle,
  input  logic               ie_err,
  output logic [DB_LONG-1:0] rx_data,
  output logic               rx_full,
  output logic               idle_flag,
  output logic               frame_err,
  output logic               standby,
  output logic               irq
);
  logic [DB_LONG-1:0] data_q;
  logic full_q, idle_q, ferr_q, sb_q;
  logic addr_wake, line_wake, accept, idle_note;

  assign addr_wake = frame_done && sb_q && wake_on_addr && addr_bit;
  assign line_wake = idle_evt && sb_q && !wake_on_addr;
  assign accept    = (frame_done && !sb_q) || addr_wake;
  assign idle_note = idle_evt && !sb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      idle_q <= 1'b0;
      ferr_q <= 1'b0;
      sb_q   <= 1'b0;
    end else begin
      if (standby_set)                 sb_q <= 1'b1;
      else if (addr_wake || line_wake) sb_q <= 1'b0;

      if (accept) begin
        data_q <= frame_data;
        full_q <= 1'b1;
        ferr_q <= !stop_ok;
      end else if (rd_data) begin
        full_q <= 1'b0;
        ferr_q <= 1'b0;
      end

      if (idle_note)     idle_q <= 1'b1;
      else if (idle_ack) idle_q <= 1'b0;
    end
  end

  assign rx_data   = data_q;
  assign rx_full   = full_q;
  assign idle_flag = idle_q;
  assign frame_err = ferr_q;
  assign standby   = sb_q;
  assign irq       = !sb_q && ((full_q & ie_full) | (idle_q & ie_idle) | (ferr_q & ie_err));

  // R9: non-wake character in standby changes nothing
  a_r9_drop_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && standby && !(wake_on_addr && addr_bit))
      |=> ($stable(rx_data) && !$rose(rx_full) && !$rose(frame_err)));

  // R10: address mark wakes and delivers
  a_r10_addr_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && standby && wake_on_addr && addr_bit && !standby_set)
      |=> (!standby && rx_full && rx_data == $past(frame_data)));

  // R11: idle-line wake is silent
  a_r11_quiet_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_evt && standby && !wake_on_addr && !frame_done)
      |=> (!$rose(idle_flag) && !$rose(rx_full)));

  // R5: low stop sample outside standby flags an error
  a_r5_ferr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !standby && !stop_ok) |=> frame_err);
endmodule

// File: rtl/uart_standby_rx.sv
`timescale 1ns/1ps
module uart_standby_rx
  import uart_sbrx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic       nine_bit,
  input  logic       wake_on_addr,
  input  logic       idle_after_stop,
  input  logic       standby_set,
  input  logic       rd_data,
  input  logic       idle_ack,
  input  logic       ie_full,
  input  logic       ie_idle,
  input  logic       ie_err,
  output logic [8:0] rx_data,
  output logic       rx_full,
  output logic       idle_flag,
  output logic       frame_err,
  output logic       standby,
  output logic       irq
);
  localparam int CNT_W = $clog2(idle_ticks(1'b1, OVS) + 1);

  logic               busy, start_evt, done, stop_ok, addr_bit, idle_evt;
  logic [DB_LONG-1:0] fr_data;

  sbrx_frame #(.OVS(OVS), .CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .nine(nine_bit),
    .busy(busy), .start_evt(start_evt), .done(done), .data(fr_data),
    .stop_ok(stop_ok), .addr_bit(addr_bit)
  );

  sbrx_idle #(.OVS(OVS), .CNT_W(CNT_W)) u_idle (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .nine(nine_bit),
    .after_stop(idle_after_stop), .busy(busy), .start_evt(start_evt),
    .restart(standby_set), .idle_evt(idle_evt)
  );

  sbrx_wake u_wake (
    .clk(clk), .rst_n(rst_n), .frame_done(done), .frame_data(fr_data),
    .stop_ok(stop_ok), .addr_bit(addr_bit), .idle_evt(idle_evt),
    .wake_on_addr(wake_on_addr), .standby_set(standby_set),
    .rd_data(rd_data), .idle_ack(idle_ack), .ie_full(ie_full),
    .ie_idle(ie_idle), .ie_err(ie_err), .rx_data(rx_data),
    .rx_full(rx_full), .idle_flag(idle_flag), .frame_err(frame_err),
    .standby(standby), .irq(irq)
  );

  // R12: standby masks the interrupt
  a_r12_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !irq);
endmodule

// File: tb/sim_uart_standby_rx.sv
`timescale 1ns/1ps
module sim_uart_standby_rx;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, rxd = 1'b1;
  logic nine_bit = 1'b0, wake_on_addr = 1'b0, idle_after_stop = 1'b0;
  logic standby_set = 1'b0, rd_data = 1'b0, idle_ack = 1'b0;
  logic ie_full = 1'b0, ie_idle = 1'b0, ie_err = 1'b0;
  logic [8:0] rx_data;
  logic rx_full, idle_flag, frame_err, standby, irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  uart_standby_rx u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .nine_bit(nine_bit),
    .wake_on_addr(wake_on_addr), .idle_after_stop(idle_after_stop),
    .standby_set(standby_set), .rd_data(rd_data), .idle_ack(idle_ack),
    .ie_full(ie_full), .ie_idle(ie_idle), .ie_err(ie_err),
    .rx_data(rx_data), .rx_full(rx_full), .idle_flag(idle_flag),
    .frame_err(frame_err), .standby(standby), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rd();
    rd_data = 1'b1; @(negedge clk); rd_data = 1'b0;
  endtask

  task automatic pulse_ack();
    idle_ack = 1'b1; @(negedge clk); idle_ack = 1'b0;
  endtask

  task automatic pulse_sb();
    standby_set = 1'b1; @(negedge clk); standby_set = 1'b0;
  endtask

  // start bit, data LSB first, stop bit; one sample inverted at (gbit, gph)
  task automatic send(input logic [8:0] val, input bit nb, input bit stopv,
                      input int gbit, input int gph);
    int total;
    total = nb ? 11 : 10;
    for (int b = 0; b < total; b++) begin
      logic lv;
      lv = (b == 0) ? 1'b0 : ((b == total - 1) ? stopv : val[b-1]);
      for (int p = 0; p < 16; p++) begin
        rxd = (b == gbit && p == gph) ? ~lv : lv;
        @(negedge clk);
      end
    end
    rxd = 1'b1;
  endtask

  initial begin
    cyc(3);
    chk(rx_data == 9'h0 && !rx_full && !frame_err && !idle_flag && !standby && !irq,
        "R1 reset state", {rx_data, rx_full, frame_err, idle_flag, standby, irq}, 0);
    rst_n = 1'b1;
    cyc(5);

    // R2 sweep of every 8-bit value, R12 full interrupt, R6 read clears
    ie_full = 1'b1;
    for (int v = 0; v < 256; v++) begin
      send(9'(v), 1'b0, 1'b1, -1, 0);
      chk(rx_data == 9'(v), "R2 data8", rx_data, v);
      chk(rx_full && !frame_err, "R2 flags", {rx_full, frame_err}, 2);
      chk(irq == 1'b1, "R12 irq full", irq, 1);
      pulse_rd();
      chk(!rx_full && !irq, "R6 read clears full", {rx_full, irq}, 0);
    end

    // R3 nine-bit values
    nine_bit = 1'b1;
    for (int k = 0; k < 40; k++) begin
      int v;
      v = (k * 37 + 5) % 512;
      send(9'(v), 1'b1, 1'b1, -1, 0);
      chk(rx_data == 9'(v) && rx_full, "R3 data9", rx_data, v);
      pulse_rd();
    end
    nine_bit = 1'b0;
    ie_full = 1'b0;

    // R13 single-sample glitches
    send(9'h000, 1'b0, 1'b1, 4, 9);
    chk(rx_data == 9'h000, "R13 glitch tick9", rx_data, 0);
    pulse_rd();
    send(9'h0FF, 1'b0, 1'b1, 6, 8);
    chk(rx_data == 9'h0FF, "R13 glitch tick8", rx_data, 9'h0FF);
    pulse_rd();
    send(9'h055, 1'b0, 1'b1, 2, 10);
    chk(rx_data == 9'h055, "R13 glitch tick10", rx_data, 9'h055);
    pulse_rd();

    // R4 false start then recovery
    rxd = 1'b0; cyc(5); rxd = 1'b1; cyc(300);
    chk(!rx_full, "R4 false start rejected", rx_full, 0);
    send(9'h0A7, 1'b0, 1'b1, -1, 0);
    chk(rx_full && rx_data == 9'h0A7, "R4 recovery", rx_data, 9'h0A7);
    pulse_rd();

    // R5 framing error, R6 clear
    ie_err = 1'b1;
    send(9'h03C, 1'b0, 1'b0, -1, 0);
    cyc(2);
    chk(frame_err && rx_full && rx_data == 9'h03C, "R5 framing error",
        {rx_data, rx_full, frame_err}, {9'h03C, 2'b11});
    chk(irq, "R12 irq err", irq, 1);
    pulse_rd();
    chk(!frame_err && !rx_full && !irq, "R6 read clears err", {frame_err, rx_full, irq}, 0);
    ie_err = 1'b0;

    // R7 idle flag once per idle period
    cyc(400);
    chk(idle_flag, "R7 idle set", idle_flag, 1);
    ie_idle = 1'b1; #1;
    chk(irq, "R12 irq idle", irq, 1);
    pulse_ack();
    chk(!idle_flag, "R7 ack clears", idle_flag, 0);
    cyc(400);
    chk(!idle_flag, "R7 not re-armed", idle_flag, 0);
    ie_idle = 1'b0;

    // R8 idle count start point
    idle_after_stop = 1'b0;
    send(9'h0FF, 1'b0, 1'b1, -1, 0);
    pulse_rd();
    cyc(29);
    chk(idle_flag, "R8 after-start early idle", idle_flag, 1);
    pulse_ack();
    cyc(400);
    idle_after_stop = 1'b1;
    send(9'h0FF, 1'b0, 1'b1, -1, 0);
    pulse_rd();
    cyc(29);
    chk(!idle_flag, "R8 after-stop not yet", idle_flag, 0);
    cyc(150);
    chk(idle_flag, "R8 after-stop later", idle_flag, 1);
    pulse_ack();
    idle_after_stop = 1'b0;

    // R9 / R10 address-mark standby
    send(9'h05A, 1'b0, 1'b1, -1, 0);
    pulse_rd();
    cyc(400);
    ie_idle = 1'b1; ie_full = 1'b1; #1;
    chk(idle_flag && irq, "R12 irq before standby", {idle_flag, irq}, 3);
    wake_on_addr = 1'b1;
    pulse_sb();
    chk(standby && !irq, "R9 irq masked", {standby, irq}, 2);
    pulse_ack();
    send(9'h012, 1'b0, 1'b1, -1, 0);
    cyc(400);
    chk(standby && !rx_full && !idle_flag && rx_data == 9'h05A, "R9 dropped char",
        {rx_data, rx_full, idle_flag, standby}, {9'h05A, 3'b001});
    send(9'h085, 1'b0, 1'b1, -1, 0);
    chk(!standby && rx_full && rx_data == 9'h085, "R10 addr wake 8",
        {rx_data, rx_full, standby}, {9'h085, 2'b10});
    chk(irq, "R12 irq after wake", irq, 1);
    pulse_rd();
    nine_bit = 1'b1;
    pulse_sb();
    send(9'h0FF, 1'b1, 1'b1, -1, 0);
    chk(standby && !rx_full && rx_data == 9'h085, "R10 bit8 clear dropped",
        {rx_data, rx_full, standby}, {9'h085, 2'b01});
    send(9'h1A5, 1'b1, 1'b1, -1, 0);
    chk(!standby && rx_full && rx_data == 9'h1A5, "R10 addr wake 9",
        {rx_data, rx_full, standby}, {9'h1A5, 2'b10});
    pulse_rd();
    nine_bit = 1'b0;
    ie_idle = 1'b0; ie_full = 1'b0;

    // R11 idle-line wake
    wake_on_addr = 1'b0;
    cyc(400);
    pulse_ack();
    pulse_sb();
    cyc(100);
    chk(standby, "R11 still in standby", standby, 1);
    cyc(100);
    chk(!standby && !idle_flag && !rx_full, "R11 quiet idle wake",
        {standby, idle_flag, rx_full}, 0);
    pulse_sb();
    send(9'h085, 1'b0, 1'b1, -1, 0);
    chk(standby && !rx_full && rx_data == 9'h1A5, "R11 char dropped in idle mode",
        {rx_data, rx_full, standby}, {9'h1A5, 2'b01});
    cyc(200);
    chk(!standby && !idle_flag && !rx_full, "R11 wake after char",
        {standby, idle_flag, rx_full}, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #3600000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule